// File: doc/BRIEF.md
# MESI Snooping Cache Controller

This block keeps the coherence state and address tag of every line in a small direct-mapped cache, using the four-state Modified / Exclusive / Shared / Invalid write-back invalidation scheme. On the processor side it takes one read or write request at a time. It completes the request at once when the line already allows the access. Otherwise it asks a shared bus for a read (RD) or a read-for-ownership (RDX) transaction.

When it fetches a line for a read, it samples a wired-OR "shared" input. If no other cache holds a copy, the line is installed Exclusive. A later write to that line then completes silently, so a read followed by a write costs only one bus transaction. If the line being replaced is Modified, the controller first issues a write-back (WB) and only then fetches the new block.

On the snoop side it watches the transactions of the other caches. It raises its shared output when a snooped read matches a valid line. It raises a flush request when it holds the matching line Modified and must supply the data. It then downgrades or invalidates the line. Data storage, memory and bus arbitration sit outside the block. An address is split into a tag (upper bits) and a set index (the low $clog2(SETS) bits). Line states are coded I=00, S=01, E=10, M=11.

Top module: `mesi_cache_ctrl`

## Requirements
- R1: A read whose line is not valid with a matching tag raises bus_req with bus_cmd RD (00) at the request address. In the cycle bus_gnt is high, cpu_done is high and cpu_hit low. The line becomes E if bus_shr_in was low in that cycle, and S if it was high.
- R2: A write to a line held E completes in its request cycle (cpu_done and cpu_hit high), with no bus request, and the line becomes M.
- R3: A write to a line held S, or not held, raises bus_req with bus_cmd RDX (01) at the request address. It completes with cpu_done high and cpu_hit low in the grant cycle, leaving the line M.
- R4: A read hitting a line in M, E or S, and a write hitting a line in M, complete in the request cycle with cpu_hit high and bus_req low.
- R5: A snooped RD that matches a line held M raises snp_flush in the same cycle and leaves the line S.
- R6: A snooped RDX that matches a line held M raises snp_flush in the same cycle and leaves the line I.
- R7: A snooped RDX that matches a line held E or S invalidates it without a flush. A snooped RD that matches a line held E leaves it S.
- R8: snp_shr_out is high exactly when a snooped RD matches a valid line. snp_flush is raised only for a line held M. Both stay low when no snoop is presented.
- R9: When a request needs a set whose line is M under a different tag, the controller first issues bus_cmd WB (10) at the old line's address, without completing the request. The line becomes I, and only then is the RD or RDX for the new address issued.
- R10: A snooped WB changes no line state and raises neither snp_flush nor snp_shr_out.
- R11: A processor request whose set index equals the index of a snoop presented in the same cycle does not complete in that cycle.
- R12: After reset every line is I: no request hits, and no snoop gets a shared or flush response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor request pending, held until cpu_done |
| cpu_wr | input | 1 | Request is a write (1) or a read (0) |
| cpu_addr | input | ADDR_W | Request line address, {tag, index} |
| cpu_done | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | Completion needed no bus transaction |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | RD=00, RDX=01, WB=10, valid with bus_req |
| bus_addr | output | ADDR_W | Line address of the requested transaction |
| bus_gnt | input | 1 | Transaction performed this cycle |
| bus_shr_in | input | 1 | Wired-OR shared line sampled during an own grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Command of the snooped transaction |
| snp_addr | input | ADDR_W | Line address of the snooped transaction |
| snp_shr_out | output | 1 | Drive of the wired-OR shared line |
| snp_flush | output | 1 | This cache must supply the dirty line |

## Verification
The assertions take for granted that the processor holds cpu_req, cpu_wr and cpu_addr steady until cpu_done. They also assume that bus_gnt comes only while bus_req is high, and that a cache is never shown its own granted transaction as a snoop; the one-writer property on the state store rests on that last point. The bench keeps within these limits by modelling a single arbiter over three instances. It grants at most one requester per cycle in round-robin order and broadcasts only that winner's transaction to the other two. It also drops each processor request only after the cycle in which completion was seen. Random addresses are drawn from three tags over all sets, so evictions, upgrades and snoop clashes on one index are frequent.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    BC_RD   = 2'b00,
    BC_RDX  = 2'b01,
    BC_WB   = 2'b10,
    BC_NONE = 2'b11
  } bus_cmd_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_EVICT = 2'b01,
    PH_FILL  = 2'b10
  } phase_e;

endpackage

// File: rtl/mesi_rst_sync.sv
module mesi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q = sync_q[1];
endmodule

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int TAG_W = 6,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  // port A: processor side, read and local update
  input  logic [IDX_W-1:0] a_idx,
  output line_st_e         a_st,
  output logic [TAG_W-1:0] a_tag,
  input  logic             a_we,
  input  line_st_e         a_st_nx,
  input  logic             a_tag_we,
  input  logic [TAG_W-1:0] a_tag_nx,
  // port B: snoop side, read and state update
  input  logic [IDX_W-1:0] b_idx,
  output line_st_e         b_st,
  output logic [TAG_W-1:0] b_tag,
  input  logic             b_we,
  input  line_st_e         b_st_nx
);
  line_st_e         st_q  [SETS];
  logic [TAG_W-1:0] tag_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    localparam logic [IDX_W-1:0] SI = IDX_W'(s);
    logic     a_sel, b_sel, st_en;
    line_st_e st_d;

    always_comb begin
      a_sel = a_we && (a_idx == SI);
      b_sel = b_we && (b_idx == SI);
      st_en = a_sel || b_sel;
      st_d  = a_sel ? a_st_nx : b_st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     st_q[s] <= ST_I;
      else if (st_en) st_q[s] <= st_d;
    end

    always_ff @(posedge clk) begin
      if (a_tag_we && (a_idx == SI)) tag_q[s] <= a_tag_nx;
    end
  end

  assign a_st  = st_q[a_idx];
  assign a_tag = tag_q[a_idx];
  assign b_st  = st_q[b_idx];
  assign b_tag = tag_q[b_idx];

  // R11
  one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_we && b_we && (a_idx == b_idx)));

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             snp_valid,
  input  logic [1:0]       snp_cmd,
  input  logic [TAG_W-1:0] snp_tag,
  input  line_st_e         line_st,
  input  logic [TAG_W-1:0] line_tag,
  output logic             shr_out,
  output logic             flush,
  output logic             upd_we,
  output line_st_e         upd_st
);
  bus_cmd_e cmd;
  logic     match, is_rd, is_rdx;

  always_comb begin
    cmd     = bus_cmd_e'(snp_cmd);
    is_rd   = (cmd == BC_RD);
    is_rdx  = (cmd == BC_RDX);
    match   = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
    shr_out = match && is_rd;
    flush   = match && (line_st == ST_M) && (is_rd || is_rdx);
    upd_we  = match && (is_rd || is_rdx);
    upd_st  = is_rdx ? ST_I : ST_S;
  end
endmodule

// File: rtl/mesi_ctrl_fsm.sv
module mesi_ctrl_fsm
  import mesi_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             cpu_wr,
  input  logic [IDX_W-1:0] cpu_idx,
  input  logic [TAG_W-1:0] cpu_tag,
  input  line_st_e         st_a,
  input  logic [TAG_W-1:0] tag_a,
  input  logic             snp_valid,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic             bus_gnt,
  input  logic             bus_shr_in,
  output logic             cpu_done,
  output logic             cpu_hit,
  output logic             bus_req,
  output bus_cmd_e         bus_cmd,
  output logic [TAG_W+IDX_W-1:0] bus_addr,
  output logic             loc_we,
  output line_st_e         loc_st,
  output logic             loc_tag_we
);
  phase_e ph_q, ph_d;
  logic   valid_match, snp_clash, local_ok;

  always_comb begin
    valid_match = (st_a != ST_I) && (tag_a == cpu_tag);
    snp_clash   = snp_valid && (snp_idx == cpu_idx);
    local_ok    = valid_match && (!cpu_wr || (st_a == ST_E) || (st_a == ST_M));
  end

  always_comb begin
    ph_d       = ph_q;
    cpu_done   = 1'b0;
    cpu_hit    = 1'b0;
    bus_req    = 1'b0;
    bus_cmd    = BC_NONE;
    bus_addr   = {cpu_tag, cpu_idx};
    loc_we     = 1'b0;
    loc_st     = st_a;
    loc_tag_we = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (cpu_req && !snp_clash) begin
          if (local_ok) begin
            cpu_done = 1'b1;
            cpu_hit  = 1'b1;
            if (cpu_wr && (st_a == ST_E)) begin
              loc_we = 1'b1;
              loc_st = ST_M;
            end
          end else if (!valid_match && (st_a == ST_M)) begin
            ph_d = PH_EVICT;
          end else begin
            ph_d = PH_FILL;
          end
        end
      end
      PH_EVICT: begin
        if (st_a == ST_M) begin
          bus_req  = 1'b1;
          bus_cmd  = BC_WB;
          bus_addr = {tag_a, cpu_idx};
          if (bus_gnt) begin
            loc_we = 1'b1;
            loc_st = ST_I;
            ph_d   = PH_FILL;
          end
        end else begin
          ph_d = PH_FILL;
        end
      end
      PH_FILL: begin
        bus_req = 1'b1;
        bus_cmd = cpu_wr ? BC_RDX : BC_RD;
        if (bus_gnt) begin
          loc_we     = 1'b1;
          loc_tag_we = 1'b1;
          loc_st     = cpu_wr ? ST_M : (bus_shr_in ? ST_S : ST_E);
          cpu_done   = 1'b1;
          ph_d       = PH_IDLE;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  // R11
  clash_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && cpu_req && snp_valid && snp_idx == cpu_idx) |-> !cpu_done);

  // R9
  wb_clears_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == BC_WB) |-> ##1 (st_a != ST_M));

  // R1
  fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd != BC_WB) |-> (cpu_done && !cpu_hit));

endmodule

// File: rtl/mesi_cache_ctrl.sv
module mesi_cache_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SETS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_shr_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shr_out,
  output logic              snp_flush
);
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic             rst_q;
  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag;
  line_st_e         st_a, st_b, loc_st, upd_st;
  logic [TAG_W-1:0] tag_a, tag_b;
  logic             loc_we, loc_tag_we, upd_we;
  bus_cmd_e         cmd_e;

  assign cpu_idx = cpu_addr[IDX_W-1:0];
  assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
  assign bus_cmd = cmd_e;

  mesi_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  mesi_line_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_q),
    .a_idx    (cpu_idx),
    .a_st     (st_a),
    .a_tag    (tag_a),
    .a_we     (loc_we),
    .a_st_nx  (loc_st),
    .a_tag_we (loc_tag_we),
    .a_tag_nx (cpu_tag),
    .b_idx    (snp_idx),
    .b_st     (st_b),
    .b_tag    (tag_b),
    .b_we     (upd_we),
    .b_st_nx  (upd_st)
  );

  mesi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid (snp_valid),
    .snp_cmd   (snp_cmd),
    .snp_tag   (snp_tag),
    .line_st   (st_b),
    .line_tag  (tag_b),
    .shr_out   (snp_shr_out),
    .flush     (snp_flush),
    .upd_we    (upd_we),
    .upd_st    (upd_st)
  );

  mesi_ctrl_fsm #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_q),
    .cpu_req    (cpu_req),
    .cpu_wr     (cpu_wr),
    .cpu_idx    (cpu_idx),
    .cpu_tag    (cpu_tag),
    .st_a       (st_a),
    .tag_a      (tag_a),
    .snp_valid  (snp_valid),
    .snp_idx    (snp_idx),
    .bus_gnt    (bus_gnt),
    .bus_shr_in (bus_shr_in),
    .cpu_done   (cpu_done),
    .cpu_hit    (cpu_hit),
    .bus_req    (bus_req),
    .bus_cmd    (cmd_e),
    .bus_addr   (bus_addr),
    .loc_we     (loc_we),
    .loc_st     (loc_st),
    .loc_tag_we (loc_tag_we)
  );

  // R4
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_done && cpu_hit) |-> !bus_req);

  // R2
  owned_write_repeat_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (cpu_done && cpu_hit && cpu_wr) ##1
    (cpu_req && cpu_wr && cpu_addr == $past(cpu_addr) && !snp_valid)
    |-> (cpu_done && cpu_hit));

  // R5
  rd_flush_once_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (snp_valid && snp_cmd == 2'b00 && snp_flush) ##1
    (snp_valid && snp_addr == $past(snp_addr)) |-> !snp_flush);

  // R6
  rdx_flush_gone_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (snp_valid && snp_cmd == 2'b01 && snp_flush) ##1
    (snp_valid && snp_addr == $past(snp_addr)) |-> (!snp_flush && !snp_shr_out));

  // R10
  wb_snoop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (snp_valid && snp_cmd == 2'b10) |-> (!snp_flush && !snp_shr_out));

  // R8
  shr_needs_rd_chk: assert property (@(posedge clk) disable iff (!rst_q)
    snp_shr_out |-> (snp_valid && snp_cmd == 2'b00));

endmodule

// File: tb/tb_mesi_cache_ctrl.sv
module tb_mesi_cache_ctrl;
  localparam int NC   = 3;
  localparam int AW   = 8;
  localparam int SETS = 4;

  logic clk, rst_n;
  logic       cpu_req [NC], cpu_wr [NC], cpu_done [NC], cpu_hit [NC];
  logic       bus_req [NC], bus_gnt [NC], bus_shr_in [NC];
  logic       snp_valid [NC], snp_shr_out [NC], snp_flush [NC];
  logic [7:0] cpu_addr [NC], bus_addr [NC], snp_addr [NC];
  logic [1:0] bus_cmd [NC], snp_cmd [NC];

  int n_chk = 0, n_bad = 0, rr = 0;
  bit finished = 0;

  logic [1:0] mst  [NC][SETS];
  logic [5:0] mtag [NC][SETS];
  bit         pend [NC], pwr [NC];
  logic [7:0] paddr [NC];

  initial clk = 0;
  always #4 clk = ~clk;

  for (genvar k = 0; k < NC; k++) begin : g_c
    mesi_cache_ctrl #(.ADDR_W(AW), .SETS(SETS)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req[k]), .cpu_wr(cpu_wr[k]), .cpu_addr(cpu_addr[k]),
      .cpu_done(cpu_done[k]), .cpu_hit(cpu_hit[k]),
      .bus_req(bus_req[k]), .bus_cmd(bus_cmd[k]), .bus_addr(bus_addr[k]),
      .bus_gnt(bus_gnt[k]), .bus_shr_in(bus_shr_in[k]),
      .snp_valid(snp_valid[k]), .snp_cmd(snp_cmd[k]), .snp_addr(snp_addr[k]),
      .snp_shr_out(snp_shr_out[k]), .snp_flush(snp_flush[k])
    );
  end

  always_comb begin
    for (int k = 0; k < NC; k++) begin
      bus_shr_in[k] = 1'b0;
      for (int j = 0; j < NC; j++)
        if (j != k && snp_shr_out[j]) bus_shr_in[k] = 1'b1;
    end
  end

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic bit mmatch(input int k, input logic [7:0] a);
    return (mst[k][a[1:0]] != 2'b00) && (mtag[k][a[1:0]] == a[7:2]);
  endfunction

  function automatic bit hit_ok(input int k);
    return mmatch(k, paddr[k]) && (!pwr[k] || mst[k][paddr[k][1:0]] >= 2'b10);
  endfunction

  task automatic step(input int gprob);
    int g, ai, pi;
    logic [1:0] c;
    logic [7:0] a;
    bit m, mm, ef, es, shd, clash, expc;
    bit exp_done [NC];
    string rq;
    @(negedge clk);
    for (int k = 0; k < NC; k++) begin
      cpu_req[k] = pend[k]; cpu_wr[k] = pwr[k]; cpu_addr[k] = paddr[k];
      bus_gnt[k] = 0; snp_valid[k] = 0; snp_cmd[k] = 0; snp_addr[k] = 0;
    end
    #1;
    g = -1; c = 0; a = 0;
    if (int'($urandom_range(99)) < gprob)
      for (int i = 0; i < NC; i++)
        if (g < 0 && bus_req[(rr + i) % NC]) g = (rr + i) % NC;
    if (g >= 0) begin
      rr = (g + 1) % NC;
      bus_gnt[g] = 1; c = bus_cmd[g]; a = bus_addr[g];
      for (int k = 0; k < NC; k++)
        if (k != g) begin snp_valid[k] = 1; snp_cmd[k] = c; snp_addr[k] = a; end
    end
    #1;
    ai = int'(a[1:0]);
    // processor side of caches that are not granted
    for (int k = 0; k < NC; k++) begin
      exp_done[k] = 0;
      if (k != g) begin
        clash = pend[k] && (g >= 0) && (a[1:0] == paddr[k][1:0]);
        exp_done[k] = pend[k] && !clash && hit_ok(k);
        if (clash) rq = "R11";
        else if (pwr[k] && mst[k][paddr[k][1:0]] == 2'b10) rq = "R2";
        else rq = "R4";
        check(cpu_done[k] == exp_done[k], rq, cpu_done[k], exp_done[k]);
        if (exp_done[k]) begin
          check(cpu_hit[k] == 1'b1, rq, cpu_hit[k], 1);
          check(bus_req[k] == 1'b0, "R4", bus_req[k], 0);
        end
      end
    end
    // snoop responses
    for (int k = 0; k < NC; k++) begin
      if (g < 0) begin
        check(snp_flush[k] == 1'b0, "R8", snp_flush[k], 0);
        check(snp_shr_out[k] == 1'b0, "R8", snp_shr_out[k], 0);
      end else if (k != g) begin
        m  = mmatch(k, a);
        mm = m && (mst[k][ai] == 2'b11);
        ef = (c != 2'b10) && mm;
        es = (c == 2'b00) && m;
        if (c == 2'b10) rq = "R10";
        else if (mm) rq = (c == 2'b00) ? "R5" : "R6";
        else if (m) rq = "R7";
        else rq = "R8";
        check(snp_flush[k] == ef, rq, snp_flush[k], ef);
        check(snp_shr_out[k] == es, rq, snp_shr_out[k], es);
      end
    end
    // granted cache
    if (g >= 0) begin
      pi = int'(paddr[g][1:0]);
      check(pend[g], "R9", pend[g], 1);
      if (c == 2'b10) begin
        check(mst[g][pi] == 2'b11 && mtag[g][pi] != paddr[g][7:2], "R9", mst[g][pi], 3);
        check(a == {mtag[g][pi], paddr[g][1:0]}, "R9", a, {mtag[g][pi], paddr[g][1:0]});
        check(cpu_done[g] == 1'b0, "R9", cpu_done[g], 0);
      end else begin
        expc = pwr[g];
        rq = pwr[g] ? "R3" : "R1";
        check(c == {1'b0, expc}, rq, c, expc);
        check(a == paddr[g], rq, a, paddr[g]);
        check(!hit_ok(g), rq, hit_ok(g), 0);
        check(!(mst[g][pi] == 2'b11 && mtag[g][pi] != paddr[g][7:2]), "R9", mst[g][pi], 0);
        check(cpu_done[g] == 1'b1 && cpu_hit[g] == 1'b0, rq, {cpu_done[g], cpu_hit[g]}, 2);
      end
    end
    // model update for the coming edge
    for (int k = 0; k < NC; k++)
      if (exp_done[k] && pwr[k] && mst[k][paddr[k][1:0]] == 2'b10)
        mst[k][paddr[k][1:0]] = 2'b11;
    if (g >= 0) begin
      if (c == 2'b10) begin
        mst[g][paddr[g][1:0]] = 2'b00;
      end else begin
        shd = 0;
        for (int k = 0; k < NC; k++)
          if (k != g && mmatch(k, a)) begin
            shd = 1;
            mst[k][ai] = (c == 2'b01) ? 2'b00 : 2'b01;
          end
        mst[g][ai]  = (c == 2'b01) ? 2'b11 : (shd ? 2'b01 : 2'b10);
        mtag[g][ai] = a[7:2];
      end
    end
    for (int k = 0; k < NC; k++)
      if (cpu_done[k]) pend[k] = 0;
  endtask

  task automatic run_one(input int k, input bit wr, input logic [7:0] ad, input string rq);
    pend[k] = 1; pwr[k] = wr; paddr[k] = ad;
    for (int n = 0; n < 20 && pend[k]; n++) step(100);
    check(!pend[k], rq, pend[k], 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd4711));
    rst_n = 0;
    for (int k = 0; k < NC; k++) begin
      cpu_req[k] = 0; cpu_wr[k] = 0; cpu_addr[k] = 0; bus_gnt[k] = 0;
      snp_valid[k] = 0; snp_cmd[k] = 0; snp_addr[k] = 0;
      pend[k] = 0; pwr[k] = 0; paddr[k] = 0;
      for (int s = 0; s < SETS; s++) begin mst[k][s] = 0; mtag[k][s] = 0; end
    end
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R12: no line valid after reset
    for (int k = 0; k < NC; k++) begin
      snp_valid[k] = 1; snp_cmd[k] = 2'b00; snp_addr[k] = 8'h05;
    end
    #1;
    for (int k = 0; k < NC; k++) begin
      check(snp_shr_out[k] == 0, "R12", snp_shr_out[k], 0);
      check(snp_flush[k] == 0, "R12", snp_flush[k], 0);
      check(bus_req[k] == 0, "R12", bus_req[k], 0);
      check(cpu_done[k] == 0, "R12", cpu_done[k], 0);
    end
    for (int k = 0; k < NC; k++) snp_valid[k] = 0;

    // directed corner cases
    run_one(0, 0, 8'h05, "R1");   // unshared read -> E
    run_one(0, 1, 8'h05, "R2");   // silent E -> M
    run_one(1, 0, 8'h05, "R5");   // c0 flushes, both S
    run_one(1, 1, 8'h05, "R3");   // upgrade from S, c0 invalidated (R7)
    run_one(0, 0, 8'h05, "R5");   // c1 M flushes
    run_one(2, 1, 8'h05, "R3");   // write miss, sharers invalidated
    run_one(0, 1, 8'h05, "R6");   // c2 M flushes on RDX
    run_one(0, 0, 8'h09, "R9");   // evict M: WB first (snooped, R10)
    run_one(1, 0, 8'h0A, "R1");
    run_one(2, 0, 8'h0A, "R7");   // c1 E -> S
    run_one(0, 0, 8'h09, "R4");   // read hit

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      for (int k = 0; k < NC; k++)
        if (!pend[k] && $urandom_range(99) < 40) begin
          pend[k]  = 1;
          pwr[k]   = 1'($urandom_range(1));
          paddr[k] = {6'($urandom_range(2)), 2'($urandom_range(3))};
        end
      step(70);
    end
    for (int n = 0; n < 200 && (pend[0] || pend[1] || pend[2]); n++) step(100);
    check(!(pend[0] || pend[1] || pend[2]), "R1", pend[0] || pend[1] || pend[2], 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule